// File: doc/BRIEF.md
# Streaming 2x2 Block Matrix Multiply Unit

This unit multiplies small square matrix blocks that arrive over a single tagged input stream. Each word carries a one-bit tag. Words tagged as control load the elements of a B block into resident holding registers. Words tagged as data carry the elements of an A block. As each A element arrives, the unit multiplies it against one row of the held B block and adds the products into a bank of accumulators. Once a full A block has arrived, the unit streams out the elements of C = A·B through a valid/ready output port.

The B block stays loaded while any number of A blocks pass through it. The host orders its block products so that each B block is loaded only once. Splitting large matrices into blocks and summing partial products across blocks is left to the host. The block edge N is a parameter, and 2 is the default.

While results are being emitted, the unit accepts no input, so backpressure on the output stalls the input stream. A control word that arrives while an A block is only partly received is held in a deferral buffer. It reaches B only after that block's last result has been accepted.

Top module: `bmm_stream`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1, and every B register holds zero, so an A block sent before any control word produces all-zero results.
- R2: Each accepted control word (`in_ctrl` = 1) writes `in_data` into one B register. A load pointer steps in the order b11, b21, b12, b22 (column-major, flat index j*N+k for b_kj) and wraps to b11 after N*N words, so a single extra word overwrites only b11.
- R3: Data words (`in_ctrl` = 0) are taken as A elements in column-major order a11, a21, a12, a22. The results are emitted in column-major order c11, c21, c12, c22, where c_ij = sum over k of a_ik·b_kj.
- R4: Operands are 16-bit two's complement. Products and sums are formed on 32 bits and wrap on overflow without saturation: for example, c11 = (-32768)(-32768) + (-32768)(-32768) gives 0x80000000.
- R5: Exactly N*N results follow each group of N*N accepted data words, and none follow a partial group. The accumulators restart from zero for every block.
- R6: While `out_valid` is 1, `in_ready` is 0. While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_valid` hold their values into the next cycle.
- R7: A control word accepted while an A block is partly received does not affect that block's results. Such words are applied to B in arrival order, continuing from the load pointer, once the block's last result is accepted.
- R8: The B block stays resident, so successive A blocks with no control words between them all multiply against the same B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word is present |
| in_ready | output | 1 | Unit accepts the input word this cycle |
| in_ctrl | input | 1 | Tag: 1 = B element (control), 0 = A element (data) |
| in_data | input | DW (16) | Signed operand |
| out_valid | output | 1 | Result element is present |
| out_ready | input | 1 | Consumer accepts the result this cycle |
| out_data | output | AW (32) | Signed result element, column-major order |

## Verification
The hardest situation to reach is a control word that lands in the middle of an A block. Its effect is deferred, so it must not leak into the block in flight, yet it must take hold before the next block. The stimulus sends half an A block, then a full set of new B words, then the rest of the block and a further block. The scoreboard model applies the same deferral, so a B update that lands early or late shows up as a wrong product. Output backpressure from a pseudo-random ready pattern is run over several blocks, which exercises the input stall and output hold while results drain.

// File: rtl/bmm_pkg.sv
package bmm_pkg;
    typedef enum logic {
        PH_FILL  = 1'b0,
        PH_DRAIN = 1'b1
    } phase_t;
endpackage

// File: rtl/bmm_mac_lane.sv
module bmm_mac_lane #(
    parameter int DW = 16,
    parameter int AW = 32
) (
    input  logic signed [DW-1:0] a_i,
    input  logic signed [DW-1:0] b_i,
    input  logic        [AW-1:0] acc_i,
    output logic        [AW-1:0] acc_o
);
    logic signed [2*DW-1:0] prod;

    always_comb begin
        prod  = a_i * b_i;
        acc_o = acc_i + AW'(prod);
    end
endmodule

// File: rtl/bmm_defer_buf.sv
module bmm_defer_buf #(
    parameter int DW    = 16,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [DW-1:0]              push_data,
    input  logic                       flush,
    output logic [$clog2(DEPTH+1)-1:0] cnt,
    output logic                       full,
    output logic [DEPTH-1:0][DW-1:0]   words
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [CW-1:0]            cnt;
        logic [DEPTH-1:0][DW-1:0] w;
    } buf_t;

    buf_t q, d;

    always_comb begin
        d = q;
        if (flush) begin
            d.cnt = '0;
        end else if (push && (q.cnt != CW'(DEPTH))) begin
            d.w[IW'(q.cnt)] = push_data;
            d.cnt           = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cnt   = q.cnt;
    assign full  = (q.cnt == CW'(DEPTH));
    assign words = q.w;
endmodule

// File: rtl/bmm_stream.sv
module bmm_stream #(
    parameter int N  = 2,
    parameter int DW = 16,
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          in_ctrl,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [AW-1:0] out_data
);
    import bmm_pkg::*;

    localparam int NN  = N * N;
    localparam int RW  = (N > 1) ? $clog2(N) : 1;
    localparam int XW  = (NN > 1) ? $clog2(NN) : 1;
    localparam int CW  = $clog2(NN + 1);

    typedef struct packed {
        phase_t                 ph;
        logic [RW-1:0]          row;
        logic [RW-1:0]          col;
        logic [XW-1:0]          oidx;
        logic [XW-1:0]          bptr;
        logic [NN-1:0][DW-1:0]  b;
        logic [NN-1:0][AW-1:0]  acc;
    } regs_t;

    regs_t q, d;

    // deferral buffer for control words that arrive mid-block
    logic                  pend_push;
    logic                  pend_flush;
    logic [CW-1:0]         pend_cnt;
    logic                  pend_full;
    logic [NN-1:0][DW-1:0] pend_words;

    bmm_defer_buf #(.DW(DW), .DEPTH(NN)) u_defer (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (pend_push),
        .push_data (in_data),
        .flush     (pend_flush),
        .cnt       (pend_cnt),
        .full      (pend_full),
        .words     (pend_words)
    );

    // one multiply-accumulate lane per column of B
    logic [XW-1:0] acc_idx [N];
    logic [AW-1:0] lane_sum [N];

    for (genvar j = 0; j < N; j++) begin : g_lane
        logic [XW-1:0] b_idx;
        assign b_idx      = XW'(j * N) + XW'(q.col);
        assign acc_idx[j] = XW'(j * N) + XW'(q.row);

        bmm_mac_lane #(.DW(DW), .AW(AW)) u_lane (
            .a_i   (in_data),
            .b_i   (q.b[b_idx]),
            .acc_i (q.acc[acc_idx[j]]),
            .acc_o (lane_sum[j])
        );
    end

    logic          busy;
    logic          take;
    logic [XW-1:0] ptr;

    always_comb begin
        d          = q;
        in_ready   = 1'b0;
        pend_push  = 1'b0;
        pend_flush = 1'b0;
        ptr        = q.bptr;
        busy       = (q.row != '0) || (q.col != '0);
        take       = 1'b0;

        if (q.ph == PH_FILL) begin
            in_ready = in_ctrl ? (!busy || !pend_full) : 1'b1;
            take     = in_valid && in_ready;
            if (take && in_ctrl) begin
                if (busy) begin
                    pend_push = 1'b1;
                end else begin
                    d.b[q.bptr] = in_data;
                    d.bptr      = (q.bptr == XW'(NN - 1)) ? '0 : q.bptr + 1'b1;
                end
            end else if (take) begin
                for (int j = 0; j < N; j++) begin
                    d.acc[acc_idx[j]] = lane_sum[j];
                end
                if (q.row == RW'(N - 1)) begin
                    d.row = '0;
                    if (q.col == RW'(N - 1)) begin
                        d.col = '0;
                        d.ph  = PH_DRAIN;
                    end else begin
                        d.col = q.col + 1'b1;
                    end
                end else begin
                    d.row = q.row + 1'b1;
                end
            end
        end else if (out_ready) begin
            if (q.oidx == XW'(NN - 1)) begin
                d.oidx     = '0;
                d.ph       = PH_FILL;
                d.acc      = '0;
                pend_flush = 1'b1;
                for (int m = 0; m < NN; m++) begin
                    if (m < int'(pend_cnt)) begin
                        d.b[ptr] = pend_words[m];
                        ptr      = (ptr == XW'(NN - 1)) ? '0 : ptr + 1'b1;
                    end
                end
                d.bptr = ptr;
            end else begin
                d.oidx = q.oidx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_valid = (q.ph == PH_DRAIN);
    assign out_data  = q.acc[q.oidx];
endmodule

// File: rtl/bmm_stream_chk.sv
module bmm_stream_chk #(
    parameter int N  = 2,
    parameter int DW = 16,
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          in_ctrl,
    input logic [DW-1:0] in_data,
    input logic          out_valid,
    input logic          out_ready,
    input logic [AW-1:0] out_data
);
    localparam int NN = N * N;

    int unsigned data_seen;
    int unsigned res_seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_seen <= 0;
            res_seen  <= 0;
        end else begin
            if (in_valid && in_ready && !in_ctrl)
                data_seen <= (data_seen == NN - 1) ? 0 : data_seen + 1;
            if (out_valid && out_ready)
                res_seen <= (res_seen == NN - 1) ? 0 : res_seen + 1;
        end
    end

    // R1: quiet right after reset release
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && in_ready));

    // R5: results start only after a whole A block
    a_r5_results_after_block: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (data_seen == 0));

    // R3: a result burst ends only after N*N results
    a_r3_full_burst: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> (res_seen == 0));

    // R6: no input taken while results are pending
    a_r6_input_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R6: output held under backpressure
    a_r6_output_held: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind bmm_stream bmm_stream_chk #(.N(N), .DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_ctrl   (in_ctrl),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/bmm_stream_tb.sv
`timescale 1ns/1ps
module bmm_stream_tb;
    localparam int N  = 2;
    localparam int NN = 4;
    localparam int DW = 16;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic          in_ctrl = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [AW-1:0] out_data;

    int checks = 0;
    int errors = 0;
    int results = 0;
    int expected_total = 0;
    bit finished = 0;
    bit bp_mode = 0;
    logic [7:0] lf = 8'hA5;

    bmm_stream #(.N(N), .DW(DW), .AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_ctrl(in_ctrl), .in_data(in_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data)
    );

    always #2 clk = ~clk;

    // reference model state
    logic signed [DW-1:0] mb [NN];
    logic signed [DW-1:0] ma [NN];
    int mptr = 0;
    int mcnt = 0;
    logic [DW-1:0] mpend [$];
    logic [AW-1:0] expq [$];

    initial for (int i = 0; i < NN; i++) mb[i] = '0;

    task automatic model_accept(input bit ctrl, input logic [DW-1:0] v);
        if (ctrl) begin
            if (mcnt == 0) begin
                mb[mptr] = v;
                mptr = (mptr + 1) % NN;
            end else begin
                mpend.push_back(v);
            end
        end else begin
            ma[mcnt] = v;
            mcnt++;
            if (mcnt == NN) begin
                for (int j = 0; j < N; j++)
                    for (int i = 0; i < N; i++) begin
                        int s;
                        s = 0;
                        for (int k = 0; k < N; k++)
                            s += int'(ma[k*N+i]) * int'(mb[j*N+k]);
                        expq.push_back(AW'(s));
                        expected_total++;
                    end
                mcnt = 0;
                while (mpend.size() > 0) begin
                    mb[mptr] = mpend.pop_front();
                    mptr = (mptr + 1) % NN;
                end
            end
        end
    endtask

    task automatic send(input bit ctrl, input logic [DW-1:0] v);
        in_valid = 1'b1;
        in_ctrl  = ctrl;
        in_data  = v;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        model_accept(ctrl, v);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic load_b(input logic [DW-1:0] b11, b21, b12, b22);
        send(1, b11); send(1, b21); send(1, b12); send(1, b22);
    endtask

    task automatic send_a(input logic [DW-1:0] a11, a21, a12, a22);
        send(0, a11); send(0, a21); send(0, a12); send(0, a22);
    endtask

    // output ready pattern
    always @(posedge clk) begin
        #1;
        if (bp_mode) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            out_ready = lf[0];
        end else begin
            out_ready = 1'b1;
        end
    end

    // monitor / scoreboard
    bit prev_stall = 0;
    logic [AW-1:0] prev_data = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) begin
                checks++;
                if (!out_valid || out_data !== prev_data) begin
                    errors++;
                    $display("FAIL R6 hold: valid=%0b data=%h expected valid=1 data=%h",
                             out_valid, out_data, prev_data);
                end
            end
            if (out_valid) begin
                checks++;
                if (in_ready !== 1'b0) begin
                    errors++;
                    $display("FAIL R6 stall: in_ready=%0b expected 0", in_ready);
                end
            end
            if (out_valid && out_ready) begin
                logic [AW-1:0] e;
                checks++;
                results++;
                if (expq.size() == 0) begin
                    errors++;
                    $display("FAIL R5 extra result: got %h expected none", out_data);
                end else begin
                    e = expq.pop_front();
                    if (out_data !== e) begin
                        errors++;
                        $display("FAIL R3/R4 result: got %h expected %h", out_data, e);
                    end
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
        end
    end

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            errors++;
            $display("FAIL R1 reset: out_valid=%0b in_ready=%0b expected 0 1", out_valid, in_ready);
        end
        @(posedge clk); #1;

        // R1: B is zero after reset
        send_a(16'd5, 16'd7, -16'sd3, 16'd9);

        // R2 R3 R8: load B once, several A blocks
        load_b(16'd1, 16'd2, 16'd3, 16'd4);
        send_a(16'd1, 16'd0, 16'd0, 16'd1);
        send_a(16'd2, -16'sd1, 16'd5, 16'd3);
        send_a(-16'sd7, 16'd11, 16'd6, -16'sd2);

        // R4: wrap at 32 bits
        load_b(16'h8000, 16'h8000, 16'h7FFF, 16'h8000);
        send_a(16'h8000, 16'h7FFF, 16'h8000, 16'h8000);

        // R2: pointer wrap, single extra word overwrites b11
        load_b(16'd10, 16'd20, 16'd30, 16'd40);
        send(1, 16'd99);
        send_a(16'd1, 16'd2, 16'd3, 16'd4);

        // R7: control words mid-block are deferred
        send(0, 16'd3); send(0, 16'd4);
        load_b(-16'sd1, 16'd2, -16'sd3, 16'd4);
        send(0, 16'd5); send(0, 16'd6);
        send_a(16'd1, 16'd1, 16'd1, 16'd1);
        send(0, 16'd2);
        send(1, 16'd50);
        send(0, 16'd2); send(0, 16'd2); send(0, 16'd2);
        send_a(16'd1, 16'd0, 16'd0, 16'd1);

        // R6: backpressure over several blocks
        bp_mode = 1;
        for (int t = 0; t < 6; t++)
            send_a(DW'(t*3 + 1), DW'(-t), DW'(t*t), DW'(100 - t));
        load_b(16'd7, -16'sd8, 16'd9, 16'd123);
        send_a(-16'sd100, 16'd200, 16'd300, -16'sd400);

        // R5: partial block produces nothing
        send(0, 16'd1); send(0, 16'd2);
        repeat (60) @(posedge clk);
        bp_mode = 0;
        repeat (20) @(negedge clk);
        checks++;
        if (expq.size() != 0 || results != expected_total || out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R5 counts: results=%0d pending=%0d valid=%0b expected %0d 0 0",
                     results, expq.size(), out_valid, expected_total);
        end
        finish_run();
    end
endmodule